// File: doc/BRIEF.md
# Dual-Slope PWM Timer with Compare

This block is a 16-bit up/down timer that drives one compare output with a pulse-width waveform whose phase and frequency stay correct when settings change. It counts from zero up to a selectable TOP and then back down to zero, so each period lasts 2 × TOP timer ticks. The compare output changes when the count equals the active compare value. The direction of travel at that moment decides whether the output is set or cleared. The output frequency is the system clock divided by 2 × N × TOP, where N is the prescaler ratio.

TOP comes either from a fixed limit register or from the active compare value. The compare value is double-buffered. A new value written by software moves into the active register only at the bottom of the count, so each period stays symmetric. All logic runs on the system clock. The prescaler output only enables timer ticks.

Top module: `pwm_dual_slope_timer`

## Requirements
- R1: `presc_sel_i` picks the tick rate: 1 gives a tick every clock, 2 every 8, 3 every 64, 4 every 256 and 5 every 1024. 0, 6 and 7 stop the timer. The count changes only on tick cycles.
- R2: From reset the count is 0 and heading down. On each tick it steps by one and turns around at TOP and at 0 without repeating either end value. A count of 0 reached while heading down moves to 1 on the next tick. When TOP is 0 the count stays at 0.
- R3: With `top_src_i` = 0, TOP is the limit register that `top_wr_i` loads, and a new value applies from the next tick. With `top_src_i` = 1, TOP is the active compare value.
- R4: `cmp_wr_i` loads only the compare buffer. The active compare value takes the buffer value on a tick where the count is 0. A write made mid-period has no effect until then.
- R5: A match is a tick on which the count equals the active compare value. With `out_mode_i` = 2 the output register is set on a match reached counting up and cleared on a match reached counting down. With `out_mode_i` = 3 it does the opposite. The output register changes at the clock edge of the matching tick.
- R6: An active compare value of 0 keeps the mode-2 output low. A value equal to TOP drives it high. Mode 3 gives the opposite levels.
- R7: With `out_mode_i` = 1 and `top_src_i` = 1, each match toggles the output register, which gives a 50% duty cycle. With `out_mode_i` = 0, or mode 1 with `top_src_i` = 0, the output is disconnected, `pin_o` is 0 and the output register holds its value.
- R8: `pin_o` shows the output register only while `pin_dir_i` is 1. Otherwise it is 0, with no delay.
- R9: `match_flag_o` goes to 1 at the edge of every matching tick and stays 1 until `flag_clr_i` is 1 at a clock edge. When a match and a clear fall on the same edge, the match wins.
- R10: During reset the count, `pin_o` and `match_flag_o` are 0. The compare buffer, the active compare value and the limit register are also 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| presc_sel_i | input | 3 | Tick rate select |
| top_src_i | input | 1 | 0: TOP from limit register, 1: TOP from active compare value |
| out_mode_i | input | 2 | Output mode: 0 off, 1 toggle, 2 non-inverting, 3 inverting |
| pin_dir_i | input | 1 | Enables the compare value on the pin |
| cmp_wr_i | input | 1 | Write strobe for the compare buffer |
| cmp_data_i | input | 16 | Compare buffer write data |
| top_wr_i | input | 1 | Write strobe for the limit register |
| top_data_i | input | 16 | Limit register write data |
| flag_clr_i | input | 1 | Clears the match flag |
| pin_o | output | 1 | Compare output pin |
| match_flag_o | output | 1 | Sticky compare-match flag |
| count_o | output | 16 | Current count |

## Verification
On a tick the count, the output register and the match flag all take their new values at that same clock edge. Register writes apply from the following edge, and `pin_o` follows `pin_dir_i` and `out_mode_i` with no delay. At each rising edge the bench's reference model steps once and queues the values due after that edge. The monitor removes and compares them at the falling edge of the same cycle, and builds the expected pin from the inputs present at that moment. Prescaler spacing is measured in clock cycles between consecutive count changes.

// File: rtl/pwm_dual_slope_pkg.sv
package pwm_dual_slope_pkg;

  typedef enum logic [1:0] {
    OUT_OFF    = 2'd0,
    OUT_TOGGLE = 2'd1,
    OUT_NONINV = 2'd2,
    OUT_INV    = 2'd3
  } out_mode_e;

  localparam int unsigned PRESC_W = 10;

  // log2 of the divide ratio, -1 for stopped selections
  function automatic int presc_log2(input logic [2:0] sel);
    case (sel)
      3'd1:    return 0;
      3'd2:    return 3;
      3'd3:    return 6;
      3'd4:    return 8;
      3'd5:    return 10;
      default: return -1;
    endcase
  endfunction

endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler
  import pwm_dual_slope_pkg::*;
#(
  parameter int unsigned DIV_W = PRESC_W
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] sel_i,
  output logic       tick_o
);

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] mask;
  logic             sel_valid;
  int               lg;

  always_comb begin
    lg        = presc_log2(sel_i);
    sel_valid = (lg >= 0);
    mask      = '0;
    if (sel_valid) mask = (DIV_W'(1) << lg) - DIV_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        div_q <= '0;
    else if (sel_valid) div_q <= div_q + DIV_W'(1);
    else                div_q <= '0;
  end

  // ratios are powers of two: tick when all low bits are set
  assign tick_o = sel_valid && ((div_q & mask) == mask);

endmodule

// File: rtl/pwm_reg_bank.sv
module pwm_reg_bank #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cmp_wr_i,
  input  logic [W-1:0] cmp_data_i,
  input  logic         top_wr_i,
  input  logic [W-1:0] top_data_i,
  input  logic         top_src_i,
  input  logic         reload_i,
  output logic [W-1:0] cmp_act_o,
  output logic [W-1:0] top_eff_o
);

  logic [W-1:0] cmp_buf_q, cmp_act_q, top_fix_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmp_buf_q <= '0;
      cmp_act_q <= '0;
      top_fix_q <= '0;
    end else begin
      if (cmp_wr_i) cmp_buf_q <= cmp_data_i;
      if (top_wr_i) top_fix_q <= top_data_i;
      if (reload_i) cmp_act_q <= cmp_buf_q;
    end
  end

  // forward the buffer on the reload tick so the new TOP governs the leaving step
  always_comb begin
    if (!top_src_i)    top_eff_o = top_fix_q;
    else if (reload_i) top_eff_o = cmp_buf_q;
    else               top_eff_o = cmp_act_q;
  end

  assign cmp_act_o = cmp_act_q;

endmodule

// File: rtl/pwm_updown_counter.sv
module pwm_updown_counter #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic [W-1:0] top_i,
  output logic [W-1:0] cnt_o,
  output logic         dir_up_o,
  output logic         at_bottom_o
);

  logic [W-1:0] cnt_q, cnt_d;
  logic         up_q, up_d;

  assign at_bottom_o = (cnt_q == '0);

  always_comb begin
    cnt_d = cnt_q;
    up_d  = up_q;
    if (up_q) begin
      if (cnt_q >= top_i) begin
        up_d  = 1'b0;
        cnt_d = at_bottom_o ? cnt_q : cnt_q - W'(1);
      end else begin
        cnt_d = cnt_q + W'(1);
      end
    end else if (at_bottom_o) begin
      if (top_i != '0) begin
        up_d  = 1'b1;
        cnt_d = W'(1);
      end
    end else begin
      cnt_d = cnt_q - W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      up_q  <= 1'b0;
    end else if (tick_i) begin
      cnt_q <= cnt_d;
      up_q  <= up_d;
    end
  end

  assign cnt_o    = cnt_q;
  assign dir_up_o = up_q;

endmodule

// File: rtl/pwm_out_unit.sv
module pwm_out_unit
  import pwm_dual_slope_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic [W-1:0] cnt_i,
  input  logic [W-1:0] cmp_i,
  input  logic         dir_up_i,
  input  logic [1:0]   mode_i,
  input  logic         top_src_i,
  input  logic         pin_dir_i,
  input  logic         flag_clr_i,
  output logic         pin_o,
  output logic         flag_o
);

  out_mode_e mode;
  logic      hit, connected;
  logic      oc_q, flag_q;

  assign mode = out_mode_e'(mode_i);
  assign hit  = tick_i && (cnt_i == cmp_i);

  always_comb begin
    case (mode)
      OUT_NONINV, OUT_INV: connected = 1'b1;
      OUT_TOGGLE:          connected = top_src_i;
      default:             connected = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      oc_q <= 1'b0;
    end else if (hit && connected) begin
      case (mode)
        OUT_TOGGLE: oc_q <= ~oc_q;
        OUT_NONINV: oc_q <= dir_up_i;
        OUT_INV:    oc_q <= ~dir_up_i;
        default:    oc_q <= oc_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         flag_q <= 1'b0;
    else if (hit)        flag_q <= 1'b1;
    else if (flag_clr_i) flag_q <= 1'b0;
  end

  assign pin_o  = pin_dir_i && connected && oc_q;
  assign flag_o = flag_q;

endmodule

// File: rtl/pwm_dual_slope_timer.sv
module pwm_dual_slope_timer
  import pwm_dual_slope_pkg::*;
#(
  parameter int unsigned W       = 16,
  parameter int unsigned DIV_W   = PRESC_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [2:0]   presc_sel_i,
  input  logic         top_src_i,
  input  logic [1:0]   out_mode_i,
  input  logic         pin_dir_i,
  input  logic         cmp_wr_i,
  input  logic [W-1:0] cmp_data_i,
  input  logic         top_wr_i,
  input  logic [W-1:0] top_data_i,
  input  logic         flag_clr_i,
  output logic         pin_o,
  output logic         match_flag_o,
  output logic [W-1:0] count_o
);

  logic         tick, reload, at_bottom, dir_up;
  logic [W-1:0] cnt, cmp_act, top_eff;

  assign reload = tick && at_bottom;

  pwm_prescaler #(.DIV_W(DIV_W)) u_presc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sel_i  (presc_sel_i),
    .tick_o (tick)
  );

  pwm_reg_bank #(.W(W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cmp_wr_i   (cmp_wr_i),
    .cmp_data_i (cmp_data_i),
    .top_wr_i   (top_wr_i),
    .top_data_i (top_data_i),
    .top_src_i  (top_src_i),
    .reload_i   (reload),
    .cmp_act_o  (cmp_act),
    .top_eff_o  (top_eff)
  );

  pwm_updown_counter #(.W(W)) u_cnt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick),
    .top_i       (top_eff),
    .cnt_o       (cnt),
    .dir_up_o    (dir_up),
    .at_bottom_o (at_bottom)
  );

  pwm_out_unit #(.W(W)) u_out (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick),
    .cnt_i      (cnt),
    .cmp_i      (cmp_act),
    .dir_up_i   (dir_up),
    .mode_i     (out_mode_i),
    .top_src_i  (top_src_i),
    .pin_dir_i  (pin_dir_i),
    .flag_clr_i (flag_clr_i),
    .pin_o      (pin_o),
    .flag_o     (match_flag_o)
  );

  assign count_o = cnt;

endmodule

// File: rtl/pwm_dual_slope_timer_chk.sv
module pwm_dual_slope_timer_chk #(
  parameter int unsigned W = 16
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic [2:0]   presc_sel_i,
  input logic [1:0]   out_mode_i,
  input logic         pin_dir_i,
  input logic         flag_clr_i,
  input logic         pin_o,
  input logic         match_flag_o,
  input logic [W-1:0] count_o
);

  assert_stopped_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (presc_sel_i == 3'd0) |=> $stable(count_o));

  assert_unit_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_o != $past(count_o)) |->
      ((count_o == $past(count_o) + W'(1)) || (count_o == $past(count_o) - W'(1))));

  assert_off_mode_low_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_mode_i == 2'd0) |-> !pin_o);

  assert_input_dir_low_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pin_dir_i |-> !pin_o);

  assert_flag_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_flag_o && !flag_clr_i) |=> match_flag_o);

endmodule

bind pwm_dual_slope_timer pwm_dual_slope_timer_chk #(.W(W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .presc_sel_i  (presc_sel_i),
  .out_mode_i   (out_mode_i),
  .pin_dir_i    (pin_dir_i),
  .flag_clr_i   (flag_clr_i),
  .pin_o        (pin_o),
  .match_flag_o (match_flag_o),
  .count_o      (count_o)
);

// File: tb/pwm_dual_slope_timer_tb_top.sv
module pwm_dual_slope_timer_tb_top;

  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [2:0]   presc_sel = 3'd1;
  logic         top_src = 1'b0;
  logic [1:0]   out_mode = 2'd2;
  logic         pin_dir = 1'b1;
  logic         cmp_wr = 1'b0;
  logic [W-1:0] cmp_data = '0;
  logic         top_wr = 1'b0;
  logic [W-1:0] top_data = '0;
  logic         flag_clr = 1'b0;
  logic         pin;
  logic         flag;
  logic [W-1:0] count;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit sb_on = 1'b0;
  bit done = 1'b0;
  string phase = "R2";

  always #10 clk = ~clk;  // 50 MHz
  always @(posedge clk) cyc <= cyc + 1;

  pwm_dual_slope_timer dut_i (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .presc_sel_i  (presc_sel),
    .top_src_i    (top_src),
    .out_mode_i   (out_mode),
    .pin_dir_i    (pin_dir),
    .cmp_wr_i     (cmp_wr),
    .cmp_data_i   (cmp_data),
    .top_wr_i     (top_wr),
    .top_data_i   (top_data),
    .flag_clr_i   (flag_clr),
    .pin_o        (pin),
    .match_flag_o (flag),
    .count_o      (count)
  );

  task automatic check(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d at cycle %0d", tag, what, act, exp, cyc);
    end
  endtask

  function automatic bit connected(logic [1:0] m, logic ts);
    return (m == 2'd2) || (m == 2'd3) || (m == 2'd1 && ts);
  endfunction

  // expected items queued by the reference model, drained by the monitor
  logic [W-1:0] q_cnt[$];
  logic         q_oc[$];
  logic         q_flag[$];
  string        q_tag[$];

  logic [W-1:0] m_cnt, m_cmp_buf, m_cmp_act, m_top_fix;
  logic         m_up, m_oc, m_flag;

  always @(posedge clk) begin : ref_model
    logic [W-1:0] top_now, n_cnt;
    logic         hit, n_up, n_oc, n_flag;
    if (!rst_n) begin
      m_cnt <= '0; m_cmp_buf <= '0; m_cmp_act <= '0; m_top_fix <= '0;
      m_up <= 1'b0; m_oc <= 1'b0; m_flag <= 1'b0;
    end else if (sb_on) begin
      hit = (m_cnt == m_cmp_act);
      if (!top_src)          top_now = m_top_fix;
      else if (m_cnt == '0)  top_now = m_cmp_buf;
      else                   top_now = m_cmp_act;
      n_oc = m_oc;
      if (hit && connected(out_mode, top_src)) begin
        if (out_mode == 2'd1)      n_oc = !m_oc;
        else if (out_mode == 2'd2) n_oc = m_up;
        else                       n_oc = !m_up;
      end
      n_flag = hit ? 1'b1 : (flag_clr ? 1'b0 : m_flag);
      n_cnt = m_cnt;
      n_up  = m_up;
      if (m_up) begin
        if (m_cnt >= top_now) begin
          n_up = 1'b0;
          if (m_cnt != '0) n_cnt = m_cnt - 1;
        end else n_cnt = m_cnt + 1;
      end else if (m_cnt == '0) begin
        if (top_now != '0) begin n_up = 1'b1; n_cnt = 1; end
      end else n_cnt = m_cnt - 1;
      if (m_cnt == '0) m_cmp_act <= m_cmp_buf;
      if (cmp_wr) m_cmp_buf <= cmp_data;
      if (top_wr) m_top_fix <= top_data;
      m_cnt <= n_cnt; m_up <= n_up; m_oc <= n_oc; m_flag <= n_flag;
      q_cnt.push_back(n_cnt);
      q_oc.push_back(n_oc);
      q_flag.push_back(n_flag);
      q_tag.push_back(phase);
    end
  end

  always @(negedge clk) begin : monitor
    while (q_cnt.size() > 0) begin
      logic [W-1:0] e_cnt;
      logic e_oc, e_flag;
      string t;
      e_cnt = q_cnt.pop_front();
      e_oc = q_oc.pop_front();
      e_flag = q_flag.pop_front();
      t = q_tag.pop_front();
      check(t, "count", int'(count), int'(e_cnt));
      check(t, "pin", int'(pin), int'(pin_dir && connected(out_mode, top_src) && e_oc));
      check(t, "flag", int'(flag), int'(e_flag));
    end
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic write_cmp(logic [W-1:0] v);
    @(posedge clk); #2;
    cmp_wr = 1'b1; cmp_data = v;
    @(posedge clk); #2;
    cmp_wr = 1'b0;
  endtask

  task automatic write_top(logic [W-1:0] v);
    @(posedge clk); #2;
    top_wr = 1'b1; top_data = v;
    @(posedge clk); #2;
    top_wr = 1'b0;
  endtask

  task automatic pulse_clr();
    @(posedge clk); #2;
    flag_clr = 1'b1;
    @(posedge clk); #2;
    flag_clr = 1'b0;
  endtask

  task automatic wait_change();
    logic [W-1:0] prev;
    @(negedge clk);
    prev = count;
    do @(negedge clk); while (count == prev);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 200000);
      finish_run();
    end
  end

  initial begin : driver
    int c1, c2;
    logic [W-1:0] hold;
    // R10: reset state
    repeat (3) @(negedge clk);
    check("R10", "count", int'(count), 0);
    check("R10", "pin", int'(pin), 0);
    check("R10", "flag", int'(flag), 0);
    @(posedge clk); #2;
    rst_n = 1'b1;
    sb_on = 1'b1;

    phase = "R3";
    write_top(16'd10);
    step(10);
    phase = "R2";
    write_cmp(16'd4);
    step(45);
    phase = "R4";
    step(7);
    write_cmp(16'd7);
    step(45);
    phase = "R5";
    out_mode = 2'd3;
    step(45);

    phase = "R6";
    out_mode = 2'd2;
    write_cmp(16'd0);
    step(45);
    write_cmp(16'd10);
    step(45);
    out_mode = 2'd3;
    step(45);

    phase = "R7";
    out_mode = 2'd2;
    top_src = 1'b1;
    write_cmp(16'd6);
    step(25);
    out_mode = 2'd1;
    step(60);
    top_src = 1'b0;
    step(30);
    out_mode = 2'd0;
    step(20);

    phase = "R8";
    out_mode = 2'd2;
    write_cmp(16'd3);
    pin_dir = 1'b0;
    step(30);
    pin_dir = 1'b1;
    step(10);

    phase = "R9";
    step(15);
    pulse_clr();
    step(3);
    pulse_clr();
    flag_clr = 1'b1;
    step(30);
    flag_clr = 1'b0;
    step(20);

    phase = "R3";
    step(3);
    write_top(16'd5);
    step(40);

    sb_on = 1'b0;
    step(2);

    // R1: tick spacing per prescaler selection
    presc_sel = 3'd2;
    wait_change();
    wait_change(); c1 = cyc;
    wait_change(); c2 = cyc;
    check("R1", "ticks at /8", c2 - c1, 8);
    presc_sel = 3'd5;
    wait_change();
    wait_change(); c1 = cyc;
    wait_change(); c2 = cyc;
    check("R1", "ticks at /1024", c2 - c1, 1024);
    @(posedge clk); #2;
    presc_sel = 3'd0;
    @(negedge clk);
    hold = count;
    repeat (50) @(negedge clk);
    check("R1", "stopped count", int'(count), int'(hold));

    done = 1'b1;
    finish_run();
  end

endmodule